// File: doc/BRIEF.md
# Core Performance Event Counter Bank

This block holds ten event counters for one processor core, together with the registers that program them. Counter 0 always counts core cycles, which is event code 0x02. Counter 1 always counts one other fixed event code, set by a parameter. Counters 2 to 9 each count whatever event their 8-bit selector names. Every cycle the core presents one pulse per event code and its current execution mode. A counter advances by one when four things hold in that cycle: its enable is on, the mode filter allows the current mode, its event pulse is high, and the bank is not frozen.

Each counter is 48 bits. The low 47 bits count, and bit 47 is a sticky overflow flag that is set when the count wraps. Software reads and writes all state through a single-cycle register port. The level interrupt is the OR of every flagged counter whose interrupt enable is set. A hold-off control can mask that interrupt until the core signals an exception return. A freeze control stops all counting while the interrupt is raised.

Top module: `pmu_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every register and counter reads zero and `irq_o` is low.
- R2: Register address 0 is the control word. The count enable for counter n is at bit position P(n), where P(n) = n for n < 8 and P(n) = 32 + n - 8 for counters 8 and 9. A counter whose enable bit is clear never increments.
- R3: Register address 1 is the mode filter. `mode_i` selects one byte lane: 0 is user 32-bit, 1 is user 64-bit, 2 is kernel 64-bit, 3 is monitor 64-bit. The filter bit for counter n is lane*8 + P(n), and a counter counts only while that bit is set for the current mode.
- R4: The monitor lane bits for counters 8 and 9 (bits 56 and 57) read as zero and ignore writes, so those counters never count in mode 3. Every control and filter bit that has no function also reads as zero.
- R5: Address 2 holds the 8-bit event codes for counters 2 to 5, at bit 8*(n-2). Address 3 holds the codes for counters 6 to 9, at bit 8*(n-6). A configurable counter counts `event_i[code]`.
- R6: Counter 0 counts `event_i[2]` and counter 1 counts `event_i[FIX1_EVT]`, whatever the selector registers hold.
- R7: Counter n is read and written at address 4+n as a 48-bit value, zero-extended. When the low 47 bits wrap from all ones to zero, bit 47 becomes 1 and stays 1 until a register write clears it.
- R8: The interrupt enable for counter n is control bit P(n)+12. `irq_o` is high when some counter has both its overflow flag and its interrupt enable set, and the hold-off is clear.
- R9: Control bit 22 is the hold-off. While it is set, `irq_o` stays low. A pulse on `eret_i` clears the bit. If a control write arrives in the same cycle as the pulse, the write wins.
- R10: Control bit 20 is the freeze. While it is set and `irq_o` is high, no counter increments.
- R11: A register write to a counter takes priority over an increment in the same cycle. Writing a counter with bit 47 clear removes that counter's contribution to the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address: 0 control, 1 mode filter, 2 and 3 selectors, 4 to 13 counters |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| event_i | input | 256 | One event pulse per event code |
| mode_i | input | 2 | Current execution mode |
| eret_i | input | 1 | Exception-return pulse that clears the hold-off |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The hardest situation to reach from the ports is the interaction at the top of the count range. A counter has to wrap while freeze, hold-off and interrupt enables are in various states, and random events alone would need 2^47 increments to get there. The stimulus therefore preloads counters through the register port to within a few counts of wrapping, both in directed steps and as a frequent choice in the random phase. The random phase then toggles the control word, the mode and `eret_i`, so that freeze and hold-off are active at the moment a flag sets. A cycle-level model in the bench predicts every counter and the interrupt.

// File: rtl/pmu_pkg.sv
// Package: shared constants and bit-position helpers for the counter bank.
// Assumes a fixed bank of ten counters with a 64-bit register word.
package pmu_pkg;
    localparam int NCTR       = 10;
    localparam int RW         = 64;
    localparam int AW         = 4;
    localparam int LANES      = 4;
    localparam int LANE_W     = 8;
    localparam int IE_GAP     = 12;
    localparam int BIT_FREEZE = 20;
    localparam int BIT_HOLD   = 22;
    localparam int HIGH_BASE  = 32;
    localparam int LOW_LIMIT  = 8;
    localparam int NFIXED     = 2;
    localparam int PER_SEL    = 4;

    localparam logic [AW-1:0] ADDR_CTRL = 4'd0;
    localparam logic [AW-1:0] ADDR_MODE = 4'd1;
    localparam logic [AW-1:0] ADDR_SEL0 = 4'd2;
    localparam logic [AW-1:0] ADDR_SEL1 = 4'd3;
    localparam int            ADDR_CNT0 = 4;

    // Per-counter bit position used by enables and mode lanes
    function automatic int ctr_pos(input int n);
        return (n < LOW_LIMIT) ? n : HIGH_BASE + n - LOW_LIMIT;
    endfunction

    // Writable bits of the control word
    function automatic logic [RW-1:0] ctrl_mask();
        logic [RW-1:0] m;
        m = '0;
        for (int n = 0; n < NCTR; n++) begin
            m[ctr_pos(n)]          = 1'b1;
            m[ctr_pos(n) + IE_GAP] = 1'b1;
        end
        m[BIT_FREEZE] = 1'b1;
        m[BIT_HOLD]   = 1'b1;
        return m;
    endfunction

    // Writable bits of the mode filter; monitor lane absent above counter 7
    function automatic logic [RW-1:0] mode_mask();
        logic [RW-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++)
            for (int n = 0; n < NCTR; n++)
                if (!(l == LANES - 1 && n >= LOW_LIMIT))
                    m[l * LANE_W + ctr_pos(n)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pmu_cfg_regs.sv
// Module: control word, mode filter and event selector registers.
// Assumes a single-cycle write port; the exception-return pulse clears
// the hold-off bit unless the control word is written in the same cycle.
module pmu_cfg_regs
    import pmu_pkg::*;
#(
    parameter int SEL_W = 8,
    localparam int SR_W = SEL_W * PER_SEL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [RW-1:0]   wdata,
    input  logic            eret,
    output logic [RW-1:0]   ctrl_q,
    output logic [RW-1:0]   mode_q,
    output logic [SR_W-1:0] sel0_q,
    output logic [SR_W-1:0] sel1_q
);
    // Register update with write priority over hold-off release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
        end else begin
            if (wr && addr == ADDR_CTRL)
                ctrl_q <= wdata & ctrl_mask();
            else if (eret)
                ctrl_q[BIT_HOLD] <= 1'b0;
            if (wr && addr == ADDR_MODE)
                mode_q <= wdata & mode_mask();
            if (wr && addr == ADDR_SEL0)
                sel0_q <= wdata[SR_W-1:0];
            if (wr && addr == ADDR_SEL1)
                sel1_q <= wdata[SR_W-1:0];
        end
    end
endmodule

// File: rtl/pmu_event_gate.sv
// Module: decides whether one counter advances in this cycle.
// Assumes the event code is already resolved (fixed or selected) and that
// unimplemented filter lanes arrive as zero.
module pmu_event_gate
    import pmu_pkg::*;
#(
    parameter int SEL_W = 8,
    localparam int NEVT = 1 << SEL_W
) (
    input  logic [NEVT-1:0]  events_i,
    input  logic [SEL_W-1:0] code_i,
    input  logic             en_i,
    input  logic [LANES-1:0] filt_i,
    input  logic [1:0]       mode_i,
    input  logic             frozen_i,
    output logic             inc_o
);
    // Combine enable, mode lane, selected pulse and freeze
    always_comb begin
        inc_o = en_i && filt_i[mode_i] && events_i[code_i] && !frozen_i;
    end
endmodule

// File: rtl/pmu_counter.sv
// Module: one counter with a sticky wrap flag in its top bit.
// Assumes a register write outranks an increment in the same cycle.
module pmu_counter #(
    parameter int CW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [CW-1:0] wdata,
    input  logic          inc,
    output logic [CW-1:0] cnt_q
);
    // Load, or count the low bits and latch the wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_hit) begin
            cnt_q <= wdata;
        end else if (inc) begin
            cnt_q[CW-2:0] <= cnt_q[CW-2:0] + 1'b1;
            if (&cnt_q[CW-2:0])
                cnt_q[CW-1] <= 1'b1;
        end
    end
endmodule

// File: rtl/pmu_counter_bank.sv
// Module: top of the ten-counter performance monitor bank.
// Assumes CW <= 64 and that event code widths match SEL_W; reads are
// combinational from registered state.
module pmu_counter_bank
    import pmu_pkg::*;
#(
    parameter int            CW       = 48,
    parameter int            SEL_W    = 8,
    parameter logic [7:0]    CYC_EVT  = 8'h02,
    parameter logic [7:0]    FIX1_EVT = 8'h01,
    localparam int           NEVT     = 1 << SEL_W,
    localparam int           SR_W     = SEL_W * PER_SEL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    input  logic [NEVT-1:0] event_i,
    input  logic [1:0]      mode_i,
    input  logic            eret_i,
    output logic            irq_o
);
    logic [RW-1:0]      ctrl_q;
    logic [RW-1:0]      mode_q;
    logic [SR_W-1:0]    sel0_q;
    logic [SR_W-1:0]    sel1_q;
    logic [CW-1:0]      cnt_q [NCTR];
    logic [NCTR-1:0]    ovf_vec;
    logic [NCTR-1:0]    ie_hit;
    logic [NCTR*CW-1:0] cnt_flat;
    logic               hold_q;
    logic               freeze_en;
    logic               frozen;

    pmu_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .eret   (eret_i),
        .ctrl_q (ctrl_q),
        .mode_q (mode_q),
        .sel0_q (sel0_q),
        .sel1_q (sel1_q)
    );

    assign hold_q    = ctrl_q[BIT_HOLD];
    assign freeze_en = ctrl_q[BIT_FREEZE];
    assign irq_o     = (|ie_hit) && !hold_q;
    assign frozen    = freeze_en && irq_o;

    for (genvar n = 0; n < NCTR; n++) begin : g_ctr
        localparam int POS = ctr_pos(n);
        logic [SEL_W-1:0] code;
        logic [LANES-1:0] filt;
        logic             inc;
        logic             wr_hit;

        if (n == 0) begin : g_cyc
            assign code = SEL_W'(CYC_EVT);
        end else if (n < NFIXED) begin : g_fix
            assign code = SEL_W'(FIX1_EVT);
        end else if (n < NFIXED + PER_SEL) begin : g_sel0
            assign code = sel0_q[(n - NFIXED) * SEL_W +: SEL_W];
        end else begin : g_sel1
            assign code = sel1_q[(n - NFIXED - PER_SEL) * SEL_W +: SEL_W];
        end

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign filt[l] = mode_q[l * LANE_W + POS];
        end

        assign wr_hit = reg_wr && (reg_addr == AW'(ADDR_CNT0 + n));

        pmu_event_gate #(.SEL_W(SEL_W)) u_gate (
            .events_i (event_i),
            .code_i   (code),
            .en_i     (ctrl_q[POS]),
            .filt_i   (filt),
            .mode_i   (mode_i),
            .frozen_i (frozen),
            .inc_o    (inc)
        );

        pmu_counter #(.CW(CW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit),
            .wdata  (reg_wdata[CW-1:0]),
            .inc    (inc),
            .cnt_q  (cnt_q[n])
        );

        assign ovf_vec[n]            = cnt_q[n][CW-1];
        assign ie_hit[n]             = cnt_q[n][CW-1] && ctrl_q[POS + IE_GAP];
        assign cnt_flat[n*CW +: CW]  = cnt_q[n];
    end

    // Read multiplexer over configuration and counters
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_MODE: reg_rdata = mode_q;
            ADDR_SEL0: reg_rdata = RW'(sel0_q);
            ADDR_SEL1: reg_rdata = RW'(sel1_q);
            default: begin
                for (int n = 0; n < NCTR; n++)
                    if (reg_addr == AW'(ADDR_CNT0 + n))
                        reg_rdata = RW'(cnt_q[n]);
            end
        endcase
    end
endmodule

// File: rtl/pmu_counter_bank_chk.sv
// Module: property checker for the counter bank, attached by bind.
// Assumes it sees the bank's flags, counters and control bits by name.
module pmu_counter_bank_chk
    import pmu_pkg::*;
#(
    parameter int CW = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic [NCTR-1:0]    ovf_vec,
    input logic [NCTR*CW-1:0] cnt_flat,
    input logic               hold_q,
    input logic               freeze_en,
    input logic               reg_wr,
    input logic [AW-1:0]      reg_addr,
    input logic [RW-1:0]      mode_q
);
    localparam int MON_A = (LANES - 1) * LANE_W + ctr_pos(8);
    localparam int MON_B = (LANES - 1) * LANE_W + ctr_pos(9);

    // R1
    irq_reset_chk: assert property (@(posedge clk) !rst_n |=> !irq_o);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|ovf_vec));

    // R9
    hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> !irq_o);

    // R10
    freeze_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_en && irq_o && !reg_wr) |=> $stable(cnt_flat));

    // R4
    mon_lane_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[MON_A] && !mode_q[MON_B]);

    for (genvar i = 0; i < NCTR; i++) begin : g_sticky
        // R7
        ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_vec[i] && !(reg_wr && reg_addr == AW'(ADDR_CNT0 + i))) |=> ovf_vec[i]);
    end
endmodule

bind pmu_counter_bank pmu_counter_bank_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .ovf_vec   (ovf_vec),
    .cnt_flat  (cnt_flat),
    .hold_q    (hold_q),
    .freeze_en (freeze_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .mode_q    (mode_q)
);

// File: tb/tb_pmu_counter_bank.sv
`timescale 1ns/1ps
module tb_pmu_counter_bank;
    localparam int CW   = 48;
    localparam int SW   = 8;
    localparam int NEVT = 256;
    localparam int NC   = 10;
    localparam logic [7:0] FIX1 = 8'h01;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [63:0]     reg_wdata = '0;
    logic [63:0]     reg_rdata;
    logic [NEVT-1:0] event_i = '0;
    logic [1:0]      mode_i = '0;
    logic            eret_i = 1'b0;
    logic            irq_o;

    always #4 clk = ~clk;

    pmu_counter_bank #(.CW(CW), .SEL_W(SW), .CYC_EVT(8'h02), .FIX1_EVT(FIX1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_i(event_i),
        .mode_i(mode_i), .eret_i(eret_i), .irq_o(irq_o)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [63:0]   m_ctrl, m_mode, cmask, mmask;
    logic [31:0]   m_sel0, m_sel1;
    logic [CW-1:0] m_cnt [NC];

    function automatic int pos(input int n);
        return (n < 8) ? n : 32 + n - 8;
    endfunction

    function automatic logic m_irq();
        logic any;
        any = 1'b0;
        for (int n = 0; n < NC; n++)
            if (m_cnt[n][CW-1] && m_ctrl[pos(n) + 12]) any = 1'b1;
        return any && !m_ctrl[22];
    endfunction

    function automatic logic [7:0] code_of(input int n);
        if (n == 0) return 8'h02;
        if (n == 1) return FIX1;
        if (n < 6)  return m_sel0[(n-2)*8 +: 8];
        return m_sel1[(n-6)*8 +: 8];
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // advance one clock while keeping the model in step
    task automatic cyc();
        logic [63:0] nc, nm;
        logic [31:0] n0, n1;
        logic [CW-1:0] nk [NC];
        logic frz;
        frz = m_ctrl[20] && m_irq();
        nc = m_ctrl; nm = m_mode; n0 = m_sel0; n1 = m_sel1;
        if (reg_wr && reg_addr == 0) nc = reg_wdata & cmask;
        else if (eret_i) nc[22] = 1'b0;
        if (reg_wr && reg_addr == 1) nm = reg_wdata & mmask;
        if (reg_wr && reg_addr == 2) n0 = reg_wdata[31:0];
        if (reg_wr && reg_addr == 3) n1 = reg_wdata[31:0];
        for (int n = 0; n < NC; n++) begin
            nk[n] = m_cnt[n];
            if (reg_wr && reg_addr == 4'(4 + n))
                nk[n] = reg_wdata[CW-1:0];
            else if (m_ctrl[pos(n)] && m_mode[int'(mode_i)*8 + pos(n)] &&
                     event_i[code_of(n)] && !frz) begin
                nk[n][CW-2:0] = m_cnt[n][CW-2:0] + 1'b1;
                if (&m_cnt[n][CW-2:0]) nk[n][CW-1] = 1'b1;
            end
        end
        @(posedge clk);
        m_ctrl = nc; m_mode = nm; m_sel0 = n0; m_sel1 = n1;
        for (int n = 0; n < NC; n++) m_cnt[n] = nk[n];
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [63:0] exp);
        reg_wr = 1'b0; reg_addr = a;
        #0.1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        rd({tag, " ctrl"}, 0, m_ctrl);
        rd({tag, " mode"}, 1, m_mode);
        rd({tag, " sel0"}, 2, {32'b0, m_sel0});
        rd({tag, " sel1"}, 3, {32'b0, m_sel1});
        for (int n = 0; n < NC; n++) rd({tag, " counter"}, 4'(4 + n), 64'(m_cnt[n]));
        check({tag, " irq"}, 64'(irq_o), 64'(m_irq()));
    endtask

    task automatic pulse(input int code, input int cycles);
        event_i = '0; event_i[code] = 1'b1;
        repeat (cycles) cyc();
        event_i = '0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        cmask = '0; mmask = '0;
        for (int n = 0; n < NC; n++) begin cmask[pos(n)] = 1'b1; cmask[pos(n)+12] = 1'b1; end
        cmask[20] = 1'b1; cmask[22] = 1'b1;
        for (int l = 0; l < 4; l++)
            for (int n = 0; n < NC; n++)
                if (!(l == 3 && n >= 8)) mmask[l*8 + pos(n)] = 1'b1;
        m_ctrl = '0; m_mode = '0; m_sel0 = '0; m_sel1 = '0;
        for (int n = 0; n < NC; n++) m_cnt[n] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1");
        check("R1 irq low", 64'(irq_o), 64'd0);

        // R2 R8 R9 writable control bits
        wr(0, '1);
        rd("R2 ctrl mask", 0, 64'h0000_3003_005F_F0FF);
        // R4 unimplemented filter bits
        wr(1, '1);
        rd("R4 mode mask", 1, 64'h0003_0303_FFFF_FFFF);
        wr(0, '0); wr(1, '0);

        // R5 counter 8 through selector 1, R2 enable at bit 32
        wr(3, 64'h0000_0000_0055_0000);
        wr(1, 64'h1 << 40);
        wr(0, 64'h1 << 32);
        mode_i = 2'd1;
        pulse(8'h55, 5);
        rd("R5 counter8 counts selected event", 4'd12, 64'd5);
        rd("R2 counter6 disabled", 4'd10, 64'd0);
        // R3 filtered out in another mode
        mode_i = 2'd0;
        pulse(8'h55, 4);
        rd("R3 counter8 blocked in mode 0", 4'd12, 64'd5);
        // R4 monitor lane absent for counter 8
        mode_i = 2'd3;
        wr(1, '1);
        pulse(8'h55, 3);
        rd("R4 counter8 idle in monitor mode", 4'd12, 64'd5);
        mode_i = 2'd1;
        pulse(8'h55, 1);
        rd("R3 counter8 resumes in mode 1", 4'd12, 64'd6);

        // R6 fixed cycle counter ignores selectors
        wr(0, '0);
        wr(2, 64'h0000_0000_1111_1111);
        wr(1, (64'h1 << 40) | (64'h1 << 8));
        wr(0, 64'h1);
        pulse(8'h11, 2);
        pulse(8'h02, 3);
        rd("R6 counter0 counts code 02 only", 4'd4, 64'd3);

        // R7 R8 wrap of counter 3 with interrupt enable
        wr(2, 64'h0000_0000_0000_4000);
        wr(1, 64'h1 << 11);
        wr(0, (64'h1 << 3) | (64'h1 << 15));
        wr(4'd7, 64'h0000_7FFF_FFFF_FFFE);
        pulse(8'h40, 1);
        rd("R7 counter3 at top", 4'd7, 64'h0000_7FFF_FFFF_FFFF);
        check("R8 irq low before wrap", 64'(irq_o), 64'd0);
        pulse(8'h40, 1);
        rd("R7 counter3 wrapped with flag", 4'd7, 64'h0000_8000_0000_0000);
        check("R8 irq on wrap", 64'(irq_o), 64'd1);
        pulse(8'h40, 1);
        rd("R7 flag sticky", 4'd7, 64'h0000_8000_0000_0001);

        // R9 hold-off and release
        wr(0, (64'h1 << 3) | (64'h1 << 15) | (64'h1 << 22));
        check("R9 irq held off", 64'(irq_o), 64'd0);
        eret_i = 1'b1;
        wr(0, (64'h1 << 3) | (64'h1 << 15) | (64'h1 << 22));
        eret_i = 1'b0;
        rd("R9 write beats release", 0, (64'h1 << 3) | (64'h1 << 15) | (64'h1 << 22));
        eret_i = 1'b1; cyc(); eret_i = 1'b0;
        rd("R9 release clears hold", 0, (64'h1 << 3) | (64'h1 << 15));
        check("R9 irq after release", 64'(irq_o), 64'd1);

        // R10 freeze while interrupt raised
        wr(0, (64'h1 << 3) | (64'h1 << 15) | (64'h1 << 20));
        pulse(8'h40, 3);
        rd("R10 frozen counter3", 4'd7, 64'h0000_8000_0000_0001);

        // R11 write beats increment and clears interrupt
        event_i[8'h40] = 1'b1;
        wr(4'd7, 64'h1234);
        event_i = '0;
        rd("R11 write wins", 4'd7, 64'h1234);
        check("R11 irq cleared", 64'(irq_o), 64'd0);
        check_all("R11 model");

        // random phase: R2 R3 R5 R7 R8 R9 R10 R11 against the model
        for (int i = 0; i < 6000; i++) begin
            reg_wr = ($urandom % 6) == 0;
            reg_addr = 4'($urandom % 14);
            reg_wdata = {$urandom, $urandom};
            if (reg_addr >= 4 && ($urandom % 2) == 0)
                reg_wdata = 64'({1'b0, 47'h7FFF_FFFF_FFFF} - 48'($urandom % 6));
            for (int w = 0; w < NEVT/32; w++) event_i[w*32 +: 32] = $urandom | $urandom;
            mode_i = 2'($urandom);
            eret_i = ($urandom % 12) == 0;
            cyc();
            reg_wr = 1'b0; eret_i = 1'b0;
            check("R8 random irq", 64'(irq_o), 64'(m_irq()));
            if (i % 200 == 199) check_all("R7 random sweep");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule